// File: doc/BRIEF.md
# BT.656 timing code decoder

This block sits on an 8-bit multiplexed 4:2:2 video stream, one byte per pixel clock. It watches for the four-byte timing reference that frames every line: three preamble bytes (0xFF, 0x00, 0x00) followed by a status byte. From each accepted status byte it takes the field, vertical-interval and start/end-of-active flags. A timing code appears right before and right after the active region of every line, including retrace lines.

After a start-of-active code, the next 1440 bytes are presented at the output with a valid strobe and a sample-phase tag. The tag cycles through Cb, Y, Cr, Y and always restarts at Cb. On vertical-interval lines, a mode input decides what the output carries. It either forwards the incoming samples, which keeps any data inserted there, or replaces them with the blanking fill: 0x80 on chroma positions and 0x10 on luma positions.

Two length checks flag malformed lines. One checks the active span between the two codes. The other checks the horizontal blanking span against the 268-byte or 280-byte length that a standard-select input chooses.

Top module: `bt656_timing_decoder`

## Requirements
- R1: A status byte is accepted only when the three bytes before it are 0xFF, 0x00, 0x00, its bit 7 is 1, and its protection bits match bit3 = V^H, bit2 = F^H, bit1 = F^V and bit0 = F^V^H. Here F is bit 6, V is bit 5 and H is bit 4, with H = 0 for start-of-active and H = 1 for end-of-active. From the clock edge that registers an accepted status byte, field_o equals F, vblank_o equals V and hblank_o equals H.
- R2: A status byte with bit 7 clear, or with any protection bit wrong, changes none of field_o, vblank_o and hblank_o. Its bytes are counted as ordinary stream bytes.
- R3: valid_o is high, one clock after each byte, for exactly the first 1440 bytes that follow an accepted start-of-active status byte. valid_o is never high while hblank_o is high.
- R4: For a valid sample, phase_o gives its position in the multiplex: 0 = Cb, 1 = Y, 2 = Cr, 3 = Y. The first sample after every start-of-active code is 0.
- R5: On lines whose last accepted code had V = 0, each valid sample leaves data_o equal to the input byte.
- R6: On lines with V = 1 while pass_vbi_i is 0, data_o is 0x80 for valid samples with phase 0 or 2, and 0x10 for phase 1 or 3.
- R7: On lines with V = 1 while pass_vbi_i is 1, valid samples leave data_o equal to the input byte.
- R8: Whenever valid_o is low, data_o is 0x10.
- R9: At each accepted end-of-active code that follows a start-of-active code, act_len_err_o is set to 1 if the stream did not carry exactly 1440 bytes plus the 3 preamble bytes between the two status bytes. Otherwise it is set to 0. The value holds until the next such check.
- R10: At each accepted start-of-active code that follows an end-of-active code, blank_len_err_o is set to 1 unless exactly 268 bytes (std_625_i = 0) or 280 bytes (std_625_i = 1) lie between the end-of-active status byte and the start-of-active preamble. Otherwise it is set to 0. The value holds until the next such check.
- R11: During reset, hblank_o = 1, vblank_o = 1, field_o = 0, valid_o = 0, phase_o = 0, data_o = 0x10, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_i | input | 8 | Multiplexed 4:2:2 byte stream with embedded timing codes |
| std_625_i | input | 1 | Blanking length select: 0 = 268 bytes, 1 = 280 bytes |
| pass_vbi_i | input | 1 | 1 = forward samples on vertical-interval lines, 0 = replace them with fill |
| data_o | output | 8 | Gated sample byte |
| valid_o | output | 1 | High for bytes inside the active window |
| phase_o | output | 2 | Multiplex position of the current sample (0 Cb, 1 Y, 2 Cr, 3 Y) |
| hblank_o | output | 1 | Horizontal blanking flag from the last accepted code |
| vblank_o | output | 1 | Vertical interval flag from the last accepted code |
| field_o | output | 1 | Field flag from the last accepted code |
| act_len_err_o | output | 1 | Last active span had the wrong length |
| blank_len_err_o | output | 1 | Last horizontal blanking span had the wrong length |

## Verification
The assertions assume that a 0xFF, 0x00, 0x00 run followed by a well-formed status byte only ever occurs as a real timing code. They also assume that the two mode inputs stay constant across the window they affect. The stimulus therefore fills active samples with values from 0x20 to 0xDF, so no preamble can form inside picture data. It changes pass_vbi_i and std_625_i only between lines, and it places corrupted status bytes in blanking, where their preamble cannot shorten an active window.

// File: rtl/bt656_dec_pkg.sv
// Shared types, constants and helpers for the BT.656 timing code decoder.
// Assumes an 8-bit stream in which each timing code is FF 00 00 followed by a status byte.
package bt656_dec_pkg;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } phase_e;

    typedef struct packed {
        logic fld;
        logic vbl;
        logic eav;
    } status_t;

    localparam logic [7:0] FILL_CHROMA = 8'h80;
    localparam logic [7:0] FILL_LUMA   = 8'h10;
    localparam logic [7:0] PRE_HI      = 8'hFF;
    localparam logic [7:0] PRE_LO      = 8'h00;

    // True when the status byte has its marker bit set and consistent protection bits
    function automatic logic status_ok(input logic [7:0] xy);
        logic f, v, h;
        f = xy[6];
        v = xy[5];
        h = xy[4];
        return xy[7]
            && (xy[3] == (v ^ h))
            && (xy[2] == (f ^ h))
            && (xy[1] == (f ^ v))
            && (xy[0] == (f ^ v ^ h));
    endfunction

    // Extracts the three flags from a status byte
    function automatic status_t status_fields(input logic [7:0] xy);
        status_t s;
        s.fld = xy[6];
        s.vbl = xy[5];
        s.eav = xy[4];
        return s;
    endfunction

endpackage

// File: rtl/bt656_trs_detect.sv
// Timing reference detector.
// Keeps a short history of the stream. It raises hit_o combinationally in the cycle
// whose input byte is a well-formed status byte preceded by the preamble.
// Assumes the preamble never appears inside picture data.
module bt656_trs_detect
    import bt656_dec_pkg::*;
#(
    parameter int PREAMBLE_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] pix_i,
    output logic       hit_o,
    output status_t    status_o
);

    logic [7:0]              hist_q [PREAMBLE_LEN];
    logic [PREAMBLE_LEN-1:0] byte_ok;

    // Shift the incoming byte into the preamble history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PREAMBLE_LEN; i++) hist_q[i] <= PRE_LO;
        end else begin
            hist_q[0] <= pix_i;
            for (int i = 1; i < PREAMBLE_LEN; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // Per-position preamble match: oldest byte is FF, the rest are 00
    generate
        for (genvar g = 0; g < PREAMBLE_LEN; g++) begin : g_match
            if (g == PREAMBLE_LEN - 1) begin : g_hi
                assign byte_ok[g] = (hist_q[g] == PRE_HI);
            end else begin : g_lo
                assign byte_ok[g] = (hist_q[g] == PRE_LO);
            end
        end
    endgenerate

    // Accept the current byte as a status byte when the preamble and protection agree
    always_comb begin
        hit_o    = (&byte_ok) && status_ok(pix_i);
        status_o = status_fields(pix_i);
    end

endmodule

// File: rtl/bt656_line_timer.sv
// Line timer.
// Tracks the flags from accepted timing codes and counts bytes since the last code.
// It produces the active-window strobe and sample phase, and checks the active and
// blanking spans against their expected lengths.
// Assumes hit_i/status_i come from the detector for the byte currently on the input.
module bt656_line_timer
    import bt656_dec_pkg::*;
#(
    parameter int ACT_SAMPLES  = 1440,
    parameter int HBLANK_525   = 268,
    parameter int HBLANK_625   = 280,
    parameter int PREAMBLE_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  status_t    status_i,
    input  logic       std_625_i,
    output logic       smp_valid_o,
    output logic [1:0] smp_phase_o,
    output logic       vbl_now_o,
    output logic       valid_o,
    output logic [1:0] phase_o,
    output logic       hblank_o,
    output logic       vblank_o,
    output logic       field_o,
    output logic       act_err_o,
    output logic       blk_err_o
);

    localparam int MAX_SPAN = ACT_SAMPLES + HBLANK_625 + 4 * PREAMBLE_LEN;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_SAT     = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ACT_LIM     = CNT_W'(ACT_SAMPLES);
    localparam logic [CNT_W-1:0] ACT_EXP     = CNT_W'(ACT_SAMPLES + PREAMBLE_LEN);
    localparam logic [CNT_W-1:0] BLK_EXP_525 = CNT_W'(HBLANK_525 + PREAMBLE_LEN);
    localparam logic [CNT_W-1:0] BLK_EXP_625 = CNT_W'(HBLANK_625 + PREAMBLE_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             in_act_q;
    logic             eav_seen_q;
    logic             hblank_q, vblank_q, field_q;
    logic             act_err_q, blk_err_q;
    logic             valid_q;
    logic [1:0]       phase_q;
    logic [CNT_W-1:0] blk_exp;

    // Window decode for the byte now on the input
    always_comb begin
        smp_valid_o = in_act_q && !hit_i && (cnt_q < ACT_LIM);
        smp_phase_o = cnt_q[1:0];
        blk_exp     = std_625_i ? BLK_EXP_625 : BLK_EXP_525;
    end

    // Bytes since the last accepted code, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (hit_i)            cnt_q <= '0;
        else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end

    // Flag registers, updated only by accepted codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hblank_q   <= 1'b1;
            vblank_q   <= 1'b1;
            field_q    <= 1'b0;
            in_act_q   <= 1'b0;
            eav_seen_q <= 1'b0;
        end else if (hit_i) begin
            hblank_q   <= status_i.eav;
            vblank_q   <= status_i.vbl;
            field_q    <= status_i.fld;
            in_act_q   <= !status_i.eav;
            eav_seen_q <= status_i.eav;
        end
    end

    // Span length checks at the closing code of each span
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_err_q <= 1'b0;
            blk_err_q <= 1'b0;
        end else if (hit_i) begin
            if (status_i.eav && in_act_q)
                act_err_q <= (cnt_q != ACT_EXP);
            if (!status_i.eav && eav_seen_q && !in_act_q)
                blk_err_q <= (cnt_q != blk_exp);
        end
    end

    // Registered strobe and phase aligned with the gated data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            phase_q <= PH_CB;
        end else begin
            valid_q <= smp_valid_o;
            phase_q <= smp_phase_o;
        end
    end

    assign vbl_now_o = vblank_q;
    assign valid_o   = valid_q;
    assign phase_o   = phase_q;
    assign hblank_o  = hblank_q;
    assign vblank_o  = vblank_q;
    assign field_o   = field_q;
    assign act_err_o = act_err_q;
    assign blk_err_o = blk_err_q;

    // R2: flags only move on an accepted code
    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> ($stable(field_q) && $stable(vblank_q) && $stable(hblank_q)));

    // R3: no active sample during horizontal blanking
    assert_valid_not_hblank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !hblank_q);

    // R4: every active window opens on Cb
    assert_phase_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> (phase_q == PH_CB));

    // R4: phase advances by one per consecutive sample
    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && $past(valid_q)) |-> (phase_q == 2'($past(phase_q) + 2'd1)));

endmodule

// File: rtl/bt656_blank_gate.sv
// Output gate.
// Registers the outgoing byte. It forwards active samples, substitutes blanking fill on
// vertical-interval lines when forwarding is off, and drives luma fill outside the window.
// Assumes smp_valid_i/smp_phase_i/vbl_i describe the byte currently on pix_i.
module bt656_blank_gate
    import bt656_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] pix_i,
    input  logic       smp_valid_i,
    input  logic [1:0] smp_phase_i,
    input  logic       vbl_i,
    input  logic       pass_vbi_i,
    output logic [7:0] data_o
);

    logic [7:0] fill;
    logic [7:0] data_d;
    logic [7:0] data_q;

    // Choose the byte to present for this input
    always_comb begin
        fill = smp_phase_i[0] ? FILL_LUMA : FILL_CHROMA;
        if (!smp_valid_i)             data_d = FILL_LUMA;
        else if (vbl_i && !pass_vbi_i) data_d = fill;
        else                          data_d = pix_i;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= FILL_LUMA;
        else        data_q <= data_d;
    end

    assign data_o = data_q;

    // R5/R7: forwarded samples equal the input byte
    assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && (!vbl_i || pass_vbi_i)) |=> (data_q == $past(pix_i)));

    // R6: chroma positions of a suppressed line carry chroma fill
    assert_vbi_chroma_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && vbl_i && !pass_vbi_i && !smp_phase_i[0]) |=> (data_q == FILL_CHROMA));

    // R6: luma positions of a suppressed line carry luma fill
    assert_vbi_luma_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && vbl_i && !pass_vbi_i && smp_phase_i[0]) |=> (data_q == FILL_LUMA));

    // R8: outside the window the output rests at luma fill
    assert_idle_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> (data_q == FILL_LUMA));

endmodule

// File: rtl/bt656_timing_decoder.sv
// BT.656 timing code decoder, top level.
// Chains the code detector, the line timer and the output gate. All outputs are
// registered and refer to the byte presented one clock earlier.
// Assumes one byte per clock and no preamble pattern inside picture data.
module bt656_timing_decoder
    import bt656_dec_pkg::*;
#(
    parameter int ACT_SAMPLES = 1440,
    parameter int HBLANK_525  = 268,
    parameter int HBLANK_625  = 280
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] pix_i,
    input  logic       std_625_i,
    input  logic       pass_vbi_i,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic [1:0] phase_o,
    output logic       hblank_o,
    output logic       vblank_o,
    output logic       field_o,
    output logic       act_len_err_o,
    output logic       blank_len_err_o
);

    localparam int PREAMBLE_LEN = 3;

    logic       code_hit;
    status_t    code_status;
    logic       smp_valid;
    logic [1:0] smp_phase;
    logic       vbl_now;

    bt656_trs_detect #(
        .PREAMBLE_LEN(PREAMBLE_LEN)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_i   (pix_i),
        .hit_o   (code_hit),
        .status_o(code_status)
    );

    bt656_line_timer #(
        .ACT_SAMPLES (ACT_SAMPLES),
        .HBLANK_525  (HBLANK_525),
        .HBLANK_625  (HBLANK_625),
        .PREAMBLE_LEN(PREAMBLE_LEN)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (code_hit),
        .status_i   (code_status),
        .std_625_i  (std_625_i),
        .smp_valid_o(smp_valid),
        .smp_phase_o(smp_phase),
        .vbl_now_o  (vbl_now),
        .valid_o    (valid_o),
        .phase_o    (phase_o),
        .hblank_o   (hblank_o),
        .vblank_o   (vblank_o),
        .field_o    (field_o),
        .act_err_o  (act_len_err_o),
        .blk_err_o  (blank_len_err_o)
    );

    bt656_blank_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_i      (pix_i),
        .smp_valid_i(smp_valid),
        .smp_phase_i(smp_phase),
        .vbl_i      (vbl_now),
        .pass_vbi_i (pass_vbi_i),
        .data_o     (data_o)
    );

endmodule

// File: tb/bt656_timing_decoder_tb_top.sv
`timescale 1ns/1ps
module bt656_timing_decoder_tb_top;

    localparam int ACT   = 1440;
    localparam int HB525 = 268;
    localparam int HB625 = 280;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix = 8'h10;
    logic       std625 = 1'b0;
    logic       pass_vbi = 1'b0;

    logic [7:0] data_o;
    logic       valid_o;
    logic [1:0] phase_o;
    logic       hblank_o, vblank_o, field_o, act_err_o, blk_err_o;

    int n_checks = 0;
    int n_fail   = 0;

    // snapshot of outputs taken at each push (result of the previous byte)
    logic       s_valid, s_hb, s_vb, s_f, s_aerr, s_berr;
    logic [7:0] s_data;
    logic [1:0] s_phase;
    logic       mid_hb;

    // expectation for the byte pushed last
    logic       pend_en = 1'b0;
    logic       pend_v;
    logic [7:0] pend_d;
    logic [1:0] pend_p;
    logic       cmp_en = 1'b1;
    int         mis_cnt = 0;

    always #4 clk = ~clk;

    bt656_timing_decoder dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pix_i          (pix),
        .std_625_i      (std625),
        .pass_vbi_i     (pass_vbi),
        .data_o         (data_o),
        .valid_o        (valid_o),
        .phase_o        (phase_o),
        .hblank_o       (hblank_o),
        .vblank_o       (vblank_o),
        .field_o        (field_o),
        .act_len_err_o  (act_err_o),
        .blank_len_err_o(blk_err_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] pat(input int k);
        return 8'(32 + (k * 7) % 192);
    endfunction

    // Drive one byte; compare the previous byte's result with its expectation (R3 R4 R5 R6 R7 R8)
    task automatic push(input logic [7:0] b, input logic ev, input logic [7:0] ed, input logic [1:0] ep);
        @(negedge clk);
        s_valid = valid_o; s_data = data_o; s_phase = phase_o;
        s_hb = hblank_o; s_vb = vblank_o; s_f = field_o;
        s_aerr = act_err_o; s_berr = blk_err_o;
        if (pend_en && cmp_en) begin
            if (s_valid !== pend_v) mis_cnt++;
            else if (pend_v && (s_data !== pend_d || s_phase !== pend_p)) mis_cnt++;
            else if (!pend_v && s_data !== 8'h10) mis_cnt++; // R8
        end
        pend_en = 1'b1; pend_v = ev; pend_d = ed; pend_p = ep;
        pix = b;
    endtask

    task automatic send_code(input logic f, input logic v, input logic h);
        push(8'hFF, 1'b0, 8'h10, 2'd0);
        push(8'h00, 1'b0, 8'h10, 2'd0);
        push(8'h00, 1'b0, 8'h10, 2'd0);
        push(mk_xy(f, v, h), 1'b0, 8'h10, 2'd0);
    endtask

    task automatic send_blank(input int n);
        for (int i = 0; i < n; i++) push((i % 2) ? 8'h10 : 8'h80, 1'b0, 8'h10, 2'd0);
    endtask

    task automatic send_active(input int n, input logic v);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b, ed;
            b  = pat(k);
            ed = (v && !pass_vbi) ? ((k % 2) ? 8'h10 : 8'h80) : b;
            push(b, (k < ACT), ed, 2'(k % 4));
            if (k == 1) mid_hb = s_hb;
        end
    endtask

    task automatic line(input logic f, input logic v, input int n_act, input int n_blank);
        send_code(f, v, 1'b0);
        send_active(n_act, v);
        send_code(f, v, 1'b1);
        send_blank(n_blank);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 hblank", 16'(hblank_o), 16'd1);
        check("R11 vblank", 16'(vblank_o), 16'd1);
        check("R11 field", 16'(field_o), 16'd0);
        check("R11 valid", 16'(valid_o), 16'd0);
        check("R11 phase", 16'(phase_o), 16'd0);
        check("R11 data", 16'(data_o), 16'h10);
        check("R11 errors", 16'({act_err_o, blk_err_o}), 16'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_normal_line();
        std625 = 1'b0; pass_vbi = 1'b0;
        send_code(1'b0, 1'b1, 1'b1);
        send_blank(HB525);
        mis_cnt = 0;
        line(1'b0, 1'b0, ACT, HB525);
        check("R5 R3 R4 R8 picture line samples", 16'(mis_cnt), 16'd0);
        check("R3 hblank low inside window", 16'(mid_hb), 16'd0);
        check("R1 hblank after end code", 16'(s_hb), 16'd1);
        check("R1 vblank from code", 16'(s_vb), 16'd0);
        check("R9 good active span", 16'(s_aerr), 16'd0);
        check("R10 good blank span", 16'(s_berr), 16'd0);
    endtask

    task automatic t_vbi_suppressed();
        pass_vbi = 1'b0; mis_cnt = 0;
        line(1'b0, 1'b1, ACT, HB525);
        check("R6 vertical line filled", 16'(mis_cnt), 16'd0);
        check("R1 vblank set", 16'(s_vb), 16'd1);
    endtask

    task automatic t_vbi_forwarded();
        pass_vbi = 1'b1; mis_cnt = 0;
        line(1'b0, 1'b1, ACT, HB525);
        check("R7 vertical line forwarded", 16'(mis_cnt), 16'd0);
        pass_vbi = 1'b0;
    endtask

    task automatic t_field();
        mis_cnt = 0;
        line(1'b1, 1'b0, ACT, HB525);
        check("R1 field set", 16'(s_f), 16'd1);
        check("R4 R5 second field samples", 16'(mis_cnt), 16'd0);
    endtask

    task automatic t_bad_codes();
        send_code(1'b1, 1'b0, 1'b0);
        send_active(ACT, 1'b0);
        send_code(1'b1, 1'b0, 1'b1);
        // marker bit clear
        push(8'hFF, 1'b0, 8'h10, 2'd0); push(8'h00, 1'b0, 8'h10, 2'd0);
        push(8'h00, 1'b0, 8'h10, 2'd0); push(mk_xy(1'b0, 1'b1, 1'b0) & 8'h7F, 1'b0, 8'h10, 2'd0);
        push(8'h80, 1'b0, 8'h10, 2'd0);
        check("R2 no marker field kept", 16'(s_f), 16'd1);
        check("R2 no marker vblank kept", 16'(s_vb), 16'd0);
        check("R2 no marker hblank kept", 16'(s_hb), 16'd1);
        // protection bit wrong
        push(8'hFF, 1'b0, 8'h10, 2'd0); push(8'h00, 1'b0, 8'h10, 2'd0);
        push(8'h00, 1'b0, 8'h10, 2'd0); push(mk_xy(1'b0, 1'b1, 1'b0) ^ 8'h01, 1'b0, 8'h10, 2'd0);
        push(8'h80, 1'b0, 8'h10, 2'd0);
        check("R2 bad parity field kept", 16'(s_f), 16'd1);
        check("R2 bad parity vblank kept", 16'(s_vb), 16'd0);
        check("R2 bad parity hblank kept", 16'(s_hb), 16'd1);
        send_blank(HB525 - 10);
        line(1'b1, 1'b0, ACT, HB525);
        check("R10 ignored codes counted as blanking", 16'(s_berr), 16'd0);
    endtask

    task automatic t_active_length();
        cmp_en = 1'b0;
        line(1'b0, 1'b0, ACT - 4, HB525);
        check("R9 short line flagged", 16'(s_aerr), 16'd1);
        cmp_en = 1'b1; mis_cnt = 0;
        line(1'b0, 1'b0, ACT, HB525);
        check("R9 flag cleared by good line", 16'(s_aerr), 16'd0);
        check("R3 window after short line", 16'(mis_cnt), 16'd0);
        cmp_en = 1'b0;
        line(1'b0, 1'b0, ACT + 4, HB525);
        check("R9 long line flagged", 16'(s_aerr), 16'd1);
        cmp_en = 1'b1;
        line(1'b0, 1'b0, ACT, HB525);
        check("R9 flag cleared again", 16'(s_aerr), 16'd0);
    endtask

    task automatic t_blank_length();
        std625 = 1'b1;
        line(1'b0, 1'b0, ACT, HB625);
        check("R10 268 under 625 select", 16'(s_berr), 16'd1);
        line(1'b0, 1'b0, ACT, HB625);
        check("R10 280 under 625 select", 16'(s_berr), 16'd0);
        std625 = 1'b0;
        line(1'b0, 1'b0, ACT, HB525);
        check("R10 280 under 525 select", 16'(s_berr), 16'd1);
        line(1'b0, 1'b0, ACT, HB525);
        check("R10 268 under 525 select", 16'(s_berr), 16'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog R3 actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_normal_line();
        t_vbi_suppressed();
        t_vbi_forwarded();
        t_field();
        t_bad_codes();
        t_active_length();
        t_blank_length();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule